// File: doc/BRIEF.md
# Camera Receiver Bring-Up Sequencer

This block is the control state machine that takes a serial camera receiver and its D-PHY from a fully reset condition to streaming, and back. Software, or a higher-level controller, raises single-cycle stream-on and stream-off requests. The sequencer drives the lane-count setting and the three active-low resets: PHY shutdown, PHY reset and controller reset. It asks an external sequencer to program the PHY frequency range through a request/acknowledge handshake, and it tells the sensor when to start or stop its clock. It also watches the PHY status word.

A start runs in a fixed order. The PHY frequency-range code is looked up from the per-lane bit rate and sent over the handshake. Then the lane count is written, and the three resets are released one per cycle. The sequencer then waits for every configured lane to reach stop state, asks the sensor to start its clock, and waits for the high-speed clock to become active. Each wait is bounded by a half-second timeout, measured in clock cycles. A failed wait undoes the steps it has taken, in order, and reports which step failed.

A reference count lets several consumers share the stream. Only the first start and the last stop touch the hardware. A request that arrives while a sequence is running is held until the sequencer is idle again.

Top module: `cam_rx_bringup`

## Requirements
- R1: After reset, `phy_shutdown_n`, `phy_rst_n` and `ctrl_rst_n` are 0, `ref_count` is 0, and no request, `done` or `err` output is active.
- R2: The frequency code sent on `phy_cfg_code` is taken from the first entry of the rate table whose limit is strictly greater than the lane rate. The limits are 90, 100, 110, 125, 140, 150, 160, 180, 200, 210, 240, 250, 270, 300, 330, 360, 400, 450, 500, 550, 600, 650, 700, 750, 800, 850, 900, 950 and 1000. The codes are, in the same order, 00, 20, 40, 02, 22, 42, 04, 24, 44, 06, 26, 46, 08, 28, 48, 2a, 4a, 0c, 2c, 0e, 2e, 10, 30, 12, 32, 14, 34, 54 and 74 (hex). When `rate_valid` is 0, the rate 849 is used. A rate of 1000 or above gives `err` with `err_cause` = 1, and no reset is released. The code stays stable while `phy_cfg_req` is held.
- R3: A start runs in this order: the configuration handshake, the lane-count write, then the release of `phy_shutdown_n`, `phy_rst_n` and `ctrl_rst_n` on successive cycles, the stop-state wait, a one-cycle `sensor_start_req`, and the clock-active wait.
- R4: `lanes_cfg` is written with the number of configured lanes minus one.
- R5: The stop-state wait ends when status bit 10 is set and status bit 4+n is set for every configured lane n. The bits of unconfigured lanes are ignored.
- R6: Status bit 8 during the clock-active wait ends the start. `done` pulses and `ref_count` becomes 1. `done` and `err` are never active together.
- R7: If the stop-state wait lasts CLK_HZ/2 cycles, `err` pulses with `err_cause` = 2. All three resets go back to 0, and no `sensor_start_req` is issued.
- R8: If the clock-active wait lasts CLK_HZ/2 cycles, `sensor_stop_req` pulses. Two cycles later the three resets are 0 and `err` pulses with `err_cause` = 3.
- R9: Only a start request seen with `ref_count` at 0 runs the start sequence, and only a stop request seen with `ref_count` at 1 runs the stop sequence. Other requests change the count by one and pulse `done`. A stop request at a count of 0 leaves the count at 0.
- R10: A stop sequence pulses `sensor_stop_req`, drives all three resets to 0 two cycles later, and clears `ref_count`.
- R11: A start request that arrives while a sequence is running is held and served once the sequencer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stream_on_req | input | 1 | Single-cycle start request |
| stream_off_req | input | 1 | Single-cycle stop request |
| lane_cnt | input | LCNT_W | Number of data lanes, 1..MAX_LANES |
| rate_valid | input | 1 | `rate_mbps` is supplied |
| rate_mbps | input | RATE_W | Per-lane bit rate in Mbps |
| phy_status | input | STAT_W | PHY status word |
| phy_cfg_ack | input | 1 | Acknowledge from the PHY configuration sequencer |
| phy_cfg_req | output | 1 | PHY frequency configuration request, held until acknowledged |
| phy_cfg_code | output | CODE_W | Frequency-range code |
| lanes_cfg | output | LCFG_W | Lane count minus one |
| phy_shutdown_n | output | 1 | PHY shutdown, active low |
| phy_rst_n | output | 1 | PHY reset, active low |
| ctrl_rst_n | output | 1 | Controller reset, active low |
| sensor_start_req | output | 1 | Single-cycle sensor clock start request |
| sensor_stop_req | output | 1 | Single-cycle sensor stop request |
| busy | output | 1 | A sequence is running |
| done | output | 1 | A request completed |
| err | output | 1 | A start failed |
| err_cause | output | 2 | 0 none, 1 rate out of range, 2 stop-state timeout, 3 clock timeout |
| ref_count | output | CNT_W | Stream reference count |

## Verification
Some properties are checked by assertions on every cycle. The three resets are released in order. A sensor start is gated on a released controller and lane 0 in stop state. A non-zero count always implies the resets are released. Every sensor stop is followed by all resets asserted two cycles later. The configuration code stays steady during the handshake. `done` and `err` never coincide. Other behaviour needs the bench's scenarios: the rate-table boundaries, the lane-mask sweep over one to four lanes, the length of each timeout, the reference-count sequence with its saturation at zero, and the holding of a request made while a sequence is running.

// File: rtl/cam_rx_pkg.sv
// Shared types and the rate-to-frequency-code table for the bring-up sequencer.
package cam_rx_pkg;

    typedef enum logic [3:0] {
        S_IDLE, S_CFG, S_LANES, S_SHUT, S_PRST, S_CRST, S_WSTOP, S_SENS,
        S_WCLK, S_UNW_SENS, S_UNW_RST, S_STOP_SENS, S_STOP_RST
    } seq_state_t;

    typedef enum logic [1:0] {
        CAUSE_NONE     = 2'd0,
        CAUSE_RANGE    = 2'd1,
        CAUSE_STOP_TMO = 2'd2,
        CAUSE_CLK_TMO  = 2'd3
    } cause_t;

    localparam int RANGE_N = 29;

    // Upper rate bound (exclusive) of each table entry, in Mbps.
    localparam logic [10:0] RANGE_LIM [RANGE_N] = '{
        11'd90,  11'd100, 11'd110, 11'd125, 11'd140, 11'd150, 11'd160, 11'd180,
        11'd200, 11'd210, 11'd240, 11'd250, 11'd270, 11'd300, 11'd330, 11'd360,
        11'd400, 11'd450, 11'd500, 11'd550, 11'd600, 11'd650, 11'd700, 11'd750,
        11'd800, 11'd850, 11'd900, 11'd950, 11'd1000
    };

    // Frequency-range code paired with each bound.
    localparam logic [6:0] RANGE_CODE [RANGE_N] = '{
        7'h00, 7'h20, 7'h40, 7'h02, 7'h22, 7'h42, 7'h04, 7'h24,
        7'h44, 7'h06, 7'h26, 7'h46, 7'h08, 7'h28, 7'h48, 7'h2a,
        7'h4a, 7'h0c, 7'h2c, 7'h0e, 7'h2e, 7'h10, 7'h30, 7'h12,
        7'h32, 7'h14, 7'h34, 7'h54, 7'h74
    };

endpackage

// File: rtl/rate_range_lookup.sv
// Maps a per-lane rate to a PHY frequency-range code.
// Assumes: the rate width is at least the table's bound width; purely combinational.
module rate_range_lookup
    import cam_rx_pkg::*;
#(
    parameter int RATE_W       = 11,
    parameter int CODE_W       = 7,
    parameter int DEFAULT_MBPS = 849
) (
    input  logic              rate_valid,
    input  logic [RATE_W-1:0] rate_mbps,
    output logic [CODE_W-1:0] code,
    output logic              code_ok
);
    logic [RATE_W-1:0] eff_rate;

    // Pick the supplied rate or the default.
    always_comb eff_rate = rate_valid ? rate_mbps : RATE_W'(DEFAULT_MBPS);

    // Scan from the top so the smallest qualifying entry wins.
    always_comb begin
        code    = '0;
        code_ok = 1'b0;
        for (int i = RANGE_N - 1; i >= 0; i--) begin
            if (RATE_W'(RANGE_LIM[i]) > eff_rate) begin
                code    = CODE_W'(RANGE_CODE[i]);
                code_ok = 1'b1;
            end
        end
    end
endmodule

// File: rtl/lane_stop_detect.sv
// Reports that the clock lane and every configured data lane are in stop state.
// Assumes: data-lane stop flags sit at status bit 4+n, the clock-lane flag at bit 10.
module lane_stop_detect #(
    parameter int MAX_LANES = 4,
    parameter int STAT_W    = 16,
    parameter int LCNT_W    = 3
) (
    input  logic [LCNT_W-1:0] lanes,
    input  logic [STAT_W-1:0] status,
    output logic              all_stop
);
    localparam int DATA_BIT0 = 4;
    localparam int CLK_BIT   = 10;

    logic [MAX_LANES-1:0] lane_ok;

    for (genvar n = 0; n < MAX_LANES; n++) begin : g_lane
        // A lane counts as ready if it is unused or shows its stop flag.
        always_comb lane_ok[n] = (LCNT_W'(n) >= lanes) || status[DATA_BIT0 + n];
    end

    // Combine the clock-lane flag with every lane's verdict.
    always_comb all_stop = status[CLK_BIT] && (&lane_ok);
endmodule

// File: rtl/wait_timer.sv
// Down-counter bounding one polling wait.
// Assumes: load and run are never both needed; expired means the count reached zero.
module wait_timer #(
    parameter int TMO_CYC = 25_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expired
);
    localparam int TW = (TMO_CYC > 1) ? $clog2(TMO_CYC) : 1;

    logic [TW-1:0] cnt;

    // Reload on entry to a wait, count down while it lasts.
    always_ff @(posedge clk) begin
        if (!rst_n)                     cnt <= '0;
        else if (load)                  cnt <= TW'(TMO_CYC - 1);
        else if (run && cnt != '0)      cnt <= cnt - 1'b1;
    end

    // Flag a zero count.
    always_comb expired = (cnt == '0);
endmodule

// File: rtl/cam_rx_bringup.sv
// Bring-up and tear-down sequencer for a serial camera receiver and its D-PHY.
// Assumes: lane_cnt is in 1..MAX_LANES; requests are one-cycle pulses;
// the PHY configuration sequencer answers phy_cfg_req with phy_cfg_ack.
module cam_rx_bringup
    import cam_rx_pkg::*;
#(
    parameter int CLK_HZ    = 50_000_000,
    parameter int MAX_LANES = 4,
    parameter int STAT_W    = 16,
    parameter int RATE_W    = 11,
    parameter int CODE_W    = 7,
    parameter int CNT_W     = 4,
    parameter int LCNT_W    = $clog2(MAX_LANES + 1),
    parameter int LCFG_W    = (MAX_LANES > 1) ? $clog2(MAX_LANES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stream_on_req,
    input  logic              stream_off_req,
    input  logic [LCNT_W-1:0] lane_cnt,
    input  logic              rate_valid,
    input  logic [RATE_W-1:0] rate_mbps,
    input  logic [STAT_W-1:0] phy_status,
    input  logic              phy_cfg_ack,
    output logic              phy_cfg_req,
    output logic [CODE_W-1:0] phy_cfg_code,
    output logic [LCFG_W-1:0] lanes_cfg,
    output logic              phy_shutdown_n,
    output logic              phy_rst_n,
    output logic              ctrl_rst_n,
    output logic              sensor_start_req,
    output logic              sensor_stop_req,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [1:0]        err_cause,
    output logic [CNT_W-1:0]  ref_count
);
    localparam int TMO_CYC = CLK_HZ / 2;
    localparam int CLK_ACTIVE_BIT = 8;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    seq_state_t        state;
    cause_t            cause_q;
    logic              pend_on, pend_off;
    logic [LCNT_W-1:0] lanes_q;
    logic [CODE_W-1:0] code_q;
    logic [CODE_W-1:0] lut_code;
    logic              lut_ok;
    logic              stop_ok;
    logic              tmr_load, tmr_run, tmr_exp;

    rate_range_lookup #(
        .RATE_W(RATE_W), .CODE_W(CODE_W), .DEFAULT_MBPS(849)
    ) u_lut (
        .rate_valid(rate_valid), .rate_mbps(rate_mbps),
        .code(lut_code), .code_ok(lut_ok)
    );

    lane_stop_detect #(
        .MAX_LANES(MAX_LANES), .STAT_W(STAT_W), .LCNT_W(LCNT_W)
    ) u_stop (
        .lanes(lanes_q), .status(phy_status), .all_stop(stop_ok)
    );

    wait_timer #(.TMO_CYC(TMO_CYC)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .run(tmr_run), .expired(tmr_exp)
    );

    // Timer control: load on entry to each wait, run inside it.
    always_comb begin
        tmr_load = (state == S_CRST) || (state == S_SENS);
        tmr_run  = (state == S_WSTOP) || (state == S_WCLK);
    end

    // State-decoded request outputs.
    always_comb begin
        phy_cfg_req      = (state == S_CFG);
        sensor_start_req = (state == S_SENS);
        sensor_stop_req  = (state == S_UNW_SENS) || (state == S_STOP_SENS);
        busy             = (state != S_IDLE);
        phy_cfg_code     = code_q;
        err_cause        = cause_q;
    end

    // Main sequencer: request arbitration, start, stop, unwind and reference count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state          <= S_IDLE;
            cause_q        <= CAUSE_NONE;
            pend_on        <= 1'b0;
            pend_off       <= 1'b0;
            lanes_q        <= '0;
            code_q         <= '0;
            lanes_cfg      <= '0;
            phy_shutdown_n <= 1'b0;
            phy_rst_n      <= 1'b0;
            ctrl_rst_n     <= 1'b0;
            done           <= 1'b0;
            err            <= 1'b0;
            ref_count      <= '0;
        end else begin
            done     <= 1'b0;
            err      <= 1'b0;
            pend_on  <= pend_on  | stream_on_req;
            pend_off <= pend_off | stream_off_req;
            unique case (state)
                S_IDLE: begin
                    if (pend_on) begin
                        pend_on <= stream_on_req;
                        if (ref_count != '0) begin
                            if (ref_count != CNT_MAX) ref_count <= ref_count + 1'b1;
                            cause_q <= CAUSE_NONE;
                            done    <= 1'b1;
                        end else if (!lut_ok) begin
                            cause_q <= CAUSE_RANGE;
                            err     <= 1'b1;
                        end else begin
                            code_q  <= lut_code;
                            lanes_q <= lane_cnt;
                            state   <= S_CFG;
                        end
                    end else if (pend_off) begin
                        pend_off <= stream_off_req;
                        if (ref_count == CNT_W'(1)) begin
                            state <= S_STOP_SENS;
                        end else begin
                            if (ref_count != '0) ref_count <= ref_count - 1'b1;
                            cause_q <= CAUSE_NONE;
                            done    <= 1'b1;
                        end
                    end
                end
                S_CFG:   if (phy_cfg_ack) state <= S_LANES;
                S_LANES: begin
                    lanes_cfg <= LCFG_W'(lanes_q - 1'b1);
                    state     <= S_SHUT;
                end
                S_SHUT:  begin phy_shutdown_n <= 1'b1; state <= S_PRST; end
                S_PRST:  begin phy_rst_n      <= 1'b1; state <= S_CRST; end
                S_CRST:  begin ctrl_rst_n     <= 1'b1; state <= S_WSTOP; end
                S_WSTOP: begin
                    if (stop_ok) begin
                        state <= S_SENS;
                    end else if (tmr_exp) begin
                        cause_q <= CAUSE_STOP_TMO;
                        state   <= S_UNW_RST;
                    end
                end
                S_SENS:  state <= S_WCLK;
                S_WCLK:  begin
                    if (phy_status[CLK_ACTIVE_BIT]) begin
                        ref_count <= CNT_W'(1);
                        cause_q   <= CAUSE_NONE;
                        done      <= 1'b1;
                        state     <= S_IDLE;
                    end else if (tmr_exp) begin
                        cause_q <= CAUSE_CLK_TMO;
                        state   <= S_UNW_SENS;
                    end
                end
                S_UNW_SENS: state <= S_UNW_RST;
                S_UNW_RST: begin
                    phy_shutdown_n <= 1'b0;
                    phy_rst_n      <= 1'b0;
                    ctrl_rst_n     <= 1'b0;
                    err            <= 1'b1;
                    state          <= S_IDLE;
                end
                S_STOP_SENS: state <= S_STOP_RST;
                S_STOP_RST: begin
                    phy_shutdown_n <= 1'b0;
                    phy_rst_n      <= 1'b0;
                    ctrl_rst_n     <= 1'b0;
                    ref_count      <= '0;
                    cause_q        <= CAUSE_NONE;
                    done           <= 1'b1;
                    state          <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cam_rx_bringup_chk.sv
// Property checker for the bring-up sequencer, bound to every instance.
module cam_rx_bringup_chk #(
    parameter int STAT_W = 16,
    parameter int CODE_W = 7,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [STAT_W-1:0] phy_status,
    input logic              phy_cfg_req,
    input logic [CODE_W-1:0] phy_cfg_code,
    input logic              phy_shutdown_n,
    input logic              phy_rst_n,
    input logic              ctrl_rst_n,
    input logic              sensor_start_req,
    input logic              sensor_stop_req,
    input logic              done,
    input logic              err,
    input logic [1:0]        err_cause,
    input logic [CNT_W-1:0]  ref_count
);
    assert_phy_rst_after_shut_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phy_rst_n) |-> phy_shutdown_n);

    assert_ctrl_after_phy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_rst_n) |-> phy_rst_n);

    assert_start_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sensor_start_req |-> (ctrl_rst_n && phy_status[10] && phy_status[4]));

    assert_done_err_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));

    assert_count_live_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_count != '0) |-> (ctrl_rst_n && phy_rst_n && phy_shutdown_n));

    assert_stop_then_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sensor_stop_req |=> ##1 (!ctrl_rst_n && !phy_rst_n && !phy_shutdown_n));

    assert_clk_tmo_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (err && err_cause == 2'd3) |-> $past(sensor_stop_req, 2));

    assert_code_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_cfg_req && $past(phy_cfg_req)) |-> $stable(phy_cfg_code));

    assert_range_err_no_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (err && err_cause == 2'd1) |-> !ctrl_rst_n);
endmodule

bind cam_rx_bringup cam_rx_bringup_chk #(
    .STAT_W(STAT_W), .CODE_W(CODE_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .phy_status(phy_status),
    .phy_cfg_req(phy_cfg_req), .phy_cfg_code(phy_cfg_code),
    .phy_shutdown_n(phy_shutdown_n), .phy_rst_n(phy_rst_n), .ctrl_rst_n(ctrl_rst_n),
    .sensor_start_req(sensor_start_req), .sensor_stop_req(sensor_stop_req),
    .done(done), .err(err), .err_cause(err_cause), .ref_count(ref_count)
);

// File: tb/cam_rx_bringup_tb.sv
module cam_rx_bringup_tb;
    localparam int CLK_HZ = 200;
    localparam int TMO    = CLK_HZ / 2;

    localparam int LIM  [29] = '{90,100,110,125,140,150,160,180,200,210,240,250,270,300,
                                 330,360,400,450,500,550,600,650,700,750,800,850,900,950,1000};
    localparam int CODE [29] = '{'h00,'h20,'h40,'h02,'h22,'h42,'h04,'h24,'h44,'h06,'h26,
                                 'h46,'h08,'h28,'h48,'h2a,'h4a,'h0c,'h2c,'h0e,'h2e,'h10,
                                 'h30,'h12,'h32,'h14,'h34,'h54,'h74};

    logic        clk = 0, rst_n = 0;
    logic        stream_on_req = 0, stream_off_req = 0;
    logic [2:0]  lane_cnt = 3'd4;
    logic        rate_valid = 0;
    logic [10:0] rate_mbps = '0;
    logic [15:0] phy_status = '0;
    logic        phy_cfg_ack = 0;
    logic        phy_cfg_req;
    logic [6:0]  phy_cfg_code;
    logic [1:0]  lanes_cfg;
    logic        phy_shutdown_n, phy_rst_n, ctrl_rst_n;
    logic        sensor_start_req, sensor_stop_req, busy, done, err;
    logic [1:0]  err_cause;
    logic [3:0]  ref_count;

    int n_tests = 0, n_fail = 0;
    int cyc = 0;
    bit ack_auto = 1;
    int n_start = 0, n_stop = 0;
    int last_code = -1;
    int t_cfg, t_shut, t_prst, t_crst, t_sens, t_stop;
    logic p_shut = 0, p_prst = 0, p_crst = 0, p_cfg = 0;

    cam_rx_bringup #(.CLK_HZ(CLK_HZ)) u_dut (
        .clk(clk), .rst_n(rst_n), .stream_on_req(stream_on_req),
        .stream_off_req(stream_off_req), .lane_cnt(lane_cnt), .rate_valid(rate_valid),
        .rate_mbps(rate_mbps), .phy_status(phy_status), .phy_cfg_ack(phy_cfg_ack),
        .phy_cfg_req(phy_cfg_req), .phy_cfg_code(phy_cfg_code), .lanes_cfg(lanes_cfg),
        .phy_shutdown_n(phy_shutdown_n), .phy_rst_n(phy_rst_n), .ctrl_rst_n(ctrl_rst_n),
        .sensor_start_req(sensor_start_req), .sensor_stop_req(sensor_stop_req),
        .busy(busy), .done(done), .err(err), .err_cause(err_cause), .ref_count(ref_count)
    );

    always #10 clk = ~clk;  // 50 MHz

    // Monitor at the falling edge: event stamps, counts and the acknowledge responder.
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (phy_cfg_req && !p_cfg) begin t_cfg = cyc; last_code = phy_cfg_code; end
        if (phy_shutdown_n && !p_shut) t_shut = cyc;
        if (phy_rst_n && !p_prst)       t_prst = cyc;
        if (ctrl_rst_n && !p_crst)      t_crst = cyc;
        if (sensor_start_req) begin n_start++; t_sens = cyc; end
        if (sensor_stop_req)  begin n_stop++;  t_stop = cyc; end
        p_cfg = phy_cfg_req; p_shut = phy_shutdown_n; p_prst = phy_rst_n; p_crst = ctrl_rst_n;
        phy_cfg_ack <= ack_auto && phy_cfg_req;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Pulse a request and wait for done or err; the outcome is returned.
    task automatic run_req(input bit on, output bit got_done, output bit got_err);
        @(negedge clk);
        if (on) stream_on_req = 1; else stream_off_req = 1;
        @(negedge clk);
        stream_on_req = 0; stream_off_req = 0;
        got_done = 0; got_err = 0;
        for (int k = 0; k < 3 * TMO + 50; k++) begin
            if (done || err) begin got_done = done; got_err = err; break; end
            @(negedge clk);
        end
    endtask

    function automatic logic [15:0] ready_bits(input int lanes);
        return 16'h0400 | 16'((((1 << lanes) - 1)) << 4);
    endfunction

    initial begin
        bit d, e;
        int exp_code;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!phy_shutdown_n && !phy_rst_n && !ctrl_rst_n, "R1 resets", int'(ctrl_rst_n), 0);
        chk(ref_count == 0 && !done && !err && !sensor_start_req && !phy_cfg_req,
            "R1 idle outputs", int'(ref_count), 0);
        rst_n = 1;
        @(negedge clk);

        // R2/R6: sweep rate table boundaries
        phy_status = ready_bits(4) | 16'h0100;
        rate_valid = 1;
        for (int i = 0; i < 29; i++) begin
            for (int s = 0; s < 2; s++) begin
                rate_mbps = 11'(LIM[i] - 1 + s);
                run_req(1, d, e);
                if (s == 1 && i == 28) begin
                    chk(e && err_cause == 1, "R2 out of range err", int'(err_cause), 1);
                    chk(!ctrl_rst_n && ref_count == 0, "R2 no release", int'(ctrl_rst_n), 0);
                end else begin
                    exp_code = CODE[i + s];
                    chk(d, "R6 start done", int'(d), 1);
                    chk(last_code == exp_code, "R2 code", last_code, exp_code);
                    chk(ref_count == 1, "R6 count one", int'(ref_count), 1);
                    run_req(0, d, e);
                    chk(d && ref_count == 0 && !ctrl_rst_n, "R10 stop", int'(ref_count), 0);
                end
            end
        end
        rate_valid = 0; rate_mbps = 11'd5;
        run_req(1, d, e);
        chk(last_code == 'h14, "R2 default rate", last_code, 'h14);
        // R3: event order
        chk(t_cfg < t_shut && t_shut + 1 == t_prst && t_prst + 1 == t_crst && t_crst < t_sens,
            "R3 order", t_sens - t_cfg, 0);
        run_req(0, d, e);
        chk(t_stop < cyc && !phy_shutdown_n && !phy_rst_n, "R10 stop resets", int'(phy_rst_n), 0);

        // R4/R5/R7: lane sweep, exact mask passes, one missing lane times out
        for (int l = 1; l <= 4; l++) begin
            lane_cnt = 3'(l);
            phy_status = ready_bits(l) | 16'h0100;
            run_req(1, d, e);
            chk(d, "R5 mask pass", int'(d), 1);
            chk(lanes_cfg == 2'(l - 1), "R4 lanes minus one", int'(lanes_cfg), l - 1);
            run_req(0, d, e);
            n_start = 0;
            phy_status = (ready_bits(l) & ~(16'h0010 << (l - 1))) | 16'h0100;
            run_req(1, d, e);
            chk(e && err_cause == 2, "R7 stop timeout cause", int'(err_cause), 2);
            chk(n_start == 0, "R7 no sensor start", n_start, 0);
            chk(!phy_shutdown_n && !phy_rst_n && !ctrl_rst_n, "R7 resets back", int'(ctrl_rst_n), 0);
            chk(cyc - t_crst >= TMO && cyc - t_crst <= TMO + 6, "R7 timeout length",
                cyc - t_crst, TMO);
        end

        // R8: clock-active timeout
        lane_cnt = 3'd2; phy_status = ready_bits(2);
        n_stop = 0;
        run_req(1, d, e);
        chk(e && err_cause == 3, "R8 clock timeout cause", int'(err_cause), 3);
        chk(n_stop == 1 && cyc - t_stop == 2, "R8 sensor stop then err", cyc - t_stop, 2);
        chk(!ctrl_rst_n && ref_count == 0, "R8 resets back", int'(ctrl_rst_n), 0);

        // R9: reference count
        phy_status = ready_bits(2) | 16'h0100;
        n_start = 0; n_stop = 0;
        for (int k = 1; k <= 3; k++) begin
            run_req(1, d, e);
            chk(d && ref_count == 4'(k), "R9 count up", int'(ref_count), k);
        end
        chk(n_start == 1, "R9 one start", n_start, 1);
        for (int k = 2; k >= 0; k--) begin
            run_req(0, d, e);
            chk(d && ref_count == 4'(k), "R9 count down", int'(ref_count), k);
        end
        chk(n_stop == 1, "R9 one stop", n_stop, 1);
        run_req(0, d, e);
        chk(d && ref_count == 0 && !ctrl_rst_n, "R9 saturate zero", int'(ref_count), 0);

        // R11: second start request while the handshake stalls
        ack_auto = 0;
        @(negedge clk); stream_on_req = 1; @(negedge clk); stream_on_req = 0;
        repeat (3) @(negedge clk);
        stream_on_req = 1; @(negedge clk); stream_on_req = 0;
        chk(busy && ref_count == 0, "R11 busy while held", int'(busy), 1);
        ack_auto = 1;
        repeat (40) @(negedge clk);
        chk(ref_count == 2, "R11 held request served", int'(ref_count), 2);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule